// File: doc/BRIEF.md
# Configurable Serial Character Receiver

This block turns a serial input line back into characters. Each finished character lands in a read register together with a ready flag, a parity error flag and a framing error flag. An interrupt request can be enabled on top of the ready flag. Software either polls the ready flag or waits for the interrupt, then pulses a read strobe to take the character.

The frame shape is set at run time: 5 to 9 data bits, parity off, even or odd, and one or two stop bits. The block has two timing modes. In the oversampled mode it spots the falling edge of the start bit, checks the start bit again half a bit later, then samples each later bit at its centre using a tick input that runs at sixteen times the bit rate. In the clocked mode it samples the line on each rising edge of an incoming bit clock.

Top module: `usart_rx`

## Requirements
- R1: `cfg_dlen` selects the data length as 5 + code for codes 0 to 4 (5 to 9 bits); codes above 4 give 9 bits. Bits arrive least significant first and fill `rd_data` from bit 0. Bits of `rd_data` above the data length read 0.
- R2: In oversampled mode a start is seen only on a high-to-low change of the synchronised line. The line is sampled again on the 8th tick after that change. If it is high by then, the change is dropped as a glitch and no character is produced.
- R3: In oversampled mode, once the start is confirmed, each data, parity and stop bit is sampled every 16 ticks, which is the centre of each bit.
- R4: With `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0, the count of ones in the data plus the parity bit must be even; with `cfg_par_odd`=1 it must be odd. A mismatch sets `parity_err` for that character. With `cfg_par_en`=0, `parity_err` reads 0.
- R5: `cfg_two_stop`=0 expects one stop bit and 1 expects two. `frame_err` is set for a character if any expected stop bit is sampled low.
- R6: The cycle after the last stop bit is sampled, `data_ready` goes to 1. In that same cycle `rd_data`, `parity_err` and `frame_err` take the new character's values. They hold those values until the next character completes.
- R7: A cycle with `rd_strobe`=1 and no character completing clears both `data_ready` and `overrun` on the next cycle.
- R8: If a character completes while `data_ready` is 1 and `rd_strobe` is 0, `overrun` goes to 1. The new character replaces the old one in `rd_data`.
- R9: `irq` equals `irq_en` AND `data_ready`.
- R10: With `cfg_sync`=1, `rx_sclk` passes through two flip-flops. While idle, a rising edge that samples the line low is the start bit. Each later rising edge samples one bit. No centring delay is applied.
- R11: While `rst_n` is low, `data_ready`, `overrun`, `parity_err`, `frame_err`, `irq` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync | input | 1 | 1 = sample on the incoming bit clock, 0 = oversampled mode |
| cfg_dlen | input | 3 | Data length code: 5 + code bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| tick16 | input | 1 | Oversample tick at 16 times the bit rate |
| rx_line | input | 1 | Serial data in; idles high |
| rx_sclk | input | 1 | Incoming bit clock for the clocked mode |
| rd_strobe | input | 1 | One-cycle read of the received character |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | 9 | Last received character |
| data_ready | output | 1 | A character is waiting to be read |
| parity_err | output | 1 | Parity mismatch on the held character |
| frame_err | output | 1 | A stop bit was low on the held character |
| overrun | output | 1 | A character was overwritten before it was read |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 16-tick oversampling and holds `tick16` high. One bit period is therefore sixteen core clocks, so each character takes a few hundred cycles. This makes it possible to cover all five data lengths, both parity senses, both stop-bit counts and the error cases within a short run. A four-cycle low pulse on the line exercises the half-bit start check. An 8-cycle bit clock exercises the clocked mode through its two-flip-flop synchroniser, with the line changing while the clock is low.

// File: rtl/usart_rx_pkg.sv
package usart_rx_pkg;
  localparam int MIN_DATA = 5;
  localparam int MAX_DATA = 9;
  localparam int IDX_W    = 4;

  typedef enum logic [1:0] {
    SM_IDLE  = 2'd0,
    SM_START = 2'd1,
    SM_RUN   = 2'd2
  } samp_state_e;

  typedef struct packed {
    logic [MAX_DATA-1:0] data;
    logic                perr;
    logic                ferr;
  } rx_char_t;
endpackage

// File: rtl/usart_rx_sync.sv
module usart_rx_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/usart_rx_sampler.sv
module usart_rx_sampler
  import usart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic tick,
  input  logic line,
  input  logic sclk,
  input  logic frame_done,
  output logic bit_valid,
  output logic bit_val,
  output logic run_o
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  samp_state_e st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic line_q, sclk_q;
  logic fall, sclk_rise;

  assign fall      = line_q & ~line;
  assign sclk_rise = ~sclk_q & sclk;
  assign bit_val   = line;
  assign run_o     = (st_q == SM_RUN);

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    bit_valid = 1'b0;
    case (st_q)
      SM_IDLE: begin
        if (sync_mode) begin
          if (sclk_rise && !line) st_n = SM_RUN;
        end else if (fall) begin
          st_n  = SM_START;
          cnt_n = '0;
        end
      end
      SM_START: begin
        if (tick) begin
          if (cnt_q == CW'(HALF - 1)) begin
            st_n  = line ? SM_IDLE : SM_RUN;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      SM_RUN: begin
        if (sync_mode) begin
          bit_valid = sclk_rise;
        end else if (tick) begin
          if (cnt_q == CW'(OSR - 1)) begin
            bit_valid = 1'b1;
            cnt_n     = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: st_n = SM_IDLE;
    endcase
    if (frame_done) st_n = SM_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SM_IDLE;
      cnt_q  <= '0;
      line_q <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      line_q <= line;
      sclk_q <= sclk;
    end
  end
endmodule

// File: rtl/usart_rx_frame.sv
module usart_rx_frame
  import usart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_valid,
  input  logic     bit_val,
  input  logic [2:0] dlen_code,
  input  logic     par_en,
  input  logic     par_odd,
  input  logic     two_stop,
  output logic     done,
  output rx_char_t result
);
  logic [IDX_W-1:0]    idx_q, idx_n, n_data, n_total;
  logic [MAX_DATA-1:0] data_q, data_n, data_b;
  logic acc_q, acc_n, acc_b;
  logic perr_q, perr_n, perr_b;
  logic ferr_q, ferr_n, ferr_b;
  logic in_data, in_par, first;

  always_comb begin
    if (dlen_code > 3'd4) n_data = IDX_W'(MAX_DATA);
    else                  n_data = IDX_W'(MIN_DATA) + {1'b0, dlen_code};
    n_total = n_data + {3'b0, par_en} + 4'd1 + {3'b0, two_stop};
  end

  assign first   = (idx_q == '0);
  assign in_data = (idx_q < n_data);
  assign in_par  = par_en && (idx_q == n_data);

  always_comb begin
    data_b = first ? '0 : data_q;
    acc_b  = first ? 1'b0 : acc_q;
    perr_b = first ? 1'b0 : perr_q;
    ferr_b = first ? 1'b0 : ferr_q;
    data_n = data_q;
    acc_n  = acc_q;
    perr_n = perr_q;
    ferr_n = ferr_q;
    idx_n  = idx_q;
    done   = 1'b0;
    if (bit_valid) begin
      data_n = data_b;
      acc_n  = acc_b;
      perr_n = perr_b;
      ferr_n = ferr_b;
      if (in_data) begin
        data_n[idx_q] = bit_val;
        acc_n         = acc_b ^ bit_val;
      end else if (in_par) begin
        perr_n = ((acc_b ^ bit_val) != par_odd);
      end else begin
        ferr_n = ferr_b | ~bit_val;
      end
      if (idx_q == n_total - 4'd1) begin
        done  = 1'b1;
        idx_n = '0;
      end else begin
        idx_n = idx_q + 4'd1;
      end
    end
  end

  assign result.data = data_n;
  assign result.perr = perr_n;
  assign result.ferr = ferr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      data_q <= '0;
      acc_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else if (bit_valid) begin
      idx_q  <= idx_n;
      data_q <= data_n;
      acc_q  <= acc_n;
      perr_q <= perr_n;
      ferr_q <= ferr_n;
    end
  end
endmodule

// File: rtl/usart_rx.sv
module usart_rx
  import usart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_sync,
  input  logic [2:0]          cfg_dlen,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  input  logic                tick16,
  input  logic                rx_line,
  input  logic                rx_sclk,
  input  logic                rd_strobe,
  input  logic                irq_en,
  output logic [MAX_DATA-1:0] rd_data,
  output logic                data_ready,
  output logic                parity_err,
  output logic                frame_err,
  output logic                overrun,
  output logic                irq
);
  logic [1:0] pins_s;
  logic bit_valid, bit_val, samp_run, frame_done;
  rx_char_t result;

  logic [MAX_DATA-1:0] data_q, data_n;
  logic perr_q, perr_n, ferr_q, ferr_n, rdy_q, rdy_n, ovr_q, ovr_n;

  usart_rx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({rx_sclk, rx_line}), .q(pins_s)
  );

  usart_rx_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst_n(rst_n), .sync_mode(cfg_sync), .tick(tick16),
    .line(pins_s[0]), .sclk(pins_s[1]), .frame_done(frame_done),
    .bit_valid(bit_valid), .bit_val(bit_val), .run_o(samp_run)
  );

  usart_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
    .dlen_code(cfg_dlen), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .two_stop(cfg_two_stop), .done(frame_done), .result(result)
  );

  always_comb begin
    data_n = data_q;
    perr_n = perr_q;
    ferr_n = ferr_q;
    rdy_n  = rdy_q;
    ovr_n  = ovr_q;
    if (frame_done) begin
      data_n = result.data;
      perr_n = result.perr;
      ferr_n = result.ferr;
      rdy_n  = 1'b1;
      ovr_n  = rd_strobe ? 1'b0 : (ovr_q | rdy_q);
    end else if (rd_strobe) begin
      rdy_n = 1'b0;
      ovr_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      perr_q <= perr_n;
      ferr_q <= ferr_n;
      rdy_q  <= rdy_n;
      ovr_q  <= ovr_n;
    end
  end

  assign rd_data    = data_q;
  assign parity_err = perr_q;
  assign frame_err  = ferr_q;
  assign data_ready = rdy_q;
  assign overrun    = ovr_q;
  assign irq        = irq_en & rdy_q;
endmodule

// File: rtl/usart_rx_chk.sv
module usart_rx_chk #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_strobe,
  input logic          frame_done,
  input logic          data_ready,
  input logic          overrun,
  input logic [DW-1:0] rd_data,
  input logic          bit_valid,
  input logic          samp_run
);
  assert_ready_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(frame_done));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(rd_data));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !frame_done) |=> (!data_ready && !overrun));

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(frame_done && data_ready));

  assert_bits_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> samp_run);
endmodule

bind usart_rx usart_rx_chk #(.DW(9)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .frame_done(frame_done),
  .data_ready(data_ready), .overrun(overrun), .rd_data(rd_data),
  .bit_valid(bit_valid), .samp_run(samp_run)
);

// File: tb/usart_rx_bench.sv
module usart_rx_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_sync, cfg_par_en, cfg_par_odd, cfg_two_stop;
  logic [2:0] cfg_dlen;
  logic tick16, rx_line, rx_sclk, rd_strobe, irq_en;
  logic [8:0] rd_data;
  logic data_ready, parity_err, frame_err, overrun, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  usart_rx u_usart_rx (
    .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_dlen(cfg_dlen),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .tick16(tick16), .rx_line(rx_line),
    .rx_sclk(rx_sclk), .rd_strobe(rd_strobe), .irq_en(irq_en),
    .rd_data(rd_data), .data_ready(data_ready), .parity_err(parity_err),
    .frame_err(frame_err), .overrun(overrun), .irq(irq)
  );

  typedef struct { logic [8:0] d; logic pe; logic fe; string tag; } exp_t;
  exp_t sb[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit auto_read = 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    if (cfg_sync) begin
      @(negedge clk); rx_line = b; rx_sclk = 1'b0;
      repeat (4) @(negedge clk);
      rx_sclk = 1'b1;
      repeat (3) @(negedge clk);
    end else begin
      @(negedge clk); rx_line = b;
      repeat (15) @(negedge clk);
    end
  endtask

  task automatic send(input logic [8:0] d, input int n, input bit bad_par,
                      input bit [1:0] bad_stop, input bit push, input string tag);
    logic [8:0] mask;
    logic p;
    exp_t e;
    mask = 9'((1 << n) - 1);
    cfg_dlen = 3'(n - 5);
    p = (^(d & mask)) ^ cfg_par_odd;
    e.d = d & mask;
    e.pe = cfg_par_en & bad_par;
    e.fe = bad_stop[0] | (cfg_two_stop & bad_stop[1]);
    e.tag = tag;
    if (push) sb.push_back(e);
    put_bit(1'b0);
    for (int i = 0; i < n; i++) put_bit(d[i]);
    if (cfg_par_en) put_bit(p ^ bad_par);
    put_bit(~bad_stop[0]);
    if (cfg_two_stop) put_bit(~bad_stop[1]);
    @(negedge clk); rx_line = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  // Monitor: pops expected characters as they are presented
  initial begin
    forever begin
      @(negedge clk);
      if (auto_read && rst_n === 1'b1 && data_ready === 1'b1) begin
        if (sb.size() == 0) begin
          check("R6 unexpected character", 32'(data_ready), 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({"R1 data ", e.tag}, 32'(rd_data), 32'(e.d));
          check({"R4 parity ", e.tag}, 32'(parity_err), 32'(e.pe));
          check({"R5 framing ", e.tag}, 32'(frame_err), 32'(e.fe));
          check({"R9 irq ", e.tag}, 32'(irq), 32'(irq_en));
        end
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check("R7 ready cleared by read", 32'(data_ready), 32'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_sync = 0; cfg_dlen = 3'd3; cfg_par_en = 0; cfg_par_odd = 0;
    cfg_two_stop = 0; tick16 = 1'b1; rx_line = 1'b1; rx_sclk = 1'b0;
    rd_strobe = 1'b0; irq_en = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 reset ready", 32'(data_ready), 32'd0);
    check("R11 reset overrun", 32'(overrun), 32'd0);
    check("R11 reset data", 32'(rd_data), 32'd0);
    check("R11 reset errors", 32'({parity_err, frame_err}), 32'd0);
    check("R11 reset irq", 32'(irq), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 oversampled, 8 data bits, no parity
    send(9'h0A5, 8, 0, 2'b00, 1, "R3 8N1");
    // R1 five bits, upper argument bits must not appear; R4 even parity
    cfg_par_en = 1;
    send(9'h1F5, 5, 0, 2'b00, 1, "R1 5E1");
    cfg_par_odd = 1;
    send(9'h05A, 7, 0, 2'b00, 1, "R4 7O1");
    cfg_par_en = 0; cfg_two_stop = 1;
    send(9'h1A3, 9, 0, 2'b00, 1, "R5 9N2");
    send(9'h0C3, 6, 0, 2'b10, 1, "R5 second stop low");
    cfg_two_stop = 0; cfg_par_en = 1; cfg_par_odd = 0;
    send(9'h03C, 8, 1, 2'b00, 1, "R4 bad parity");
    cfg_par_en = 0;
    send(9'h081, 8, 0, 2'b01, 1, "R5 stop low");

    // R2 glitch: four-cycle low pulse must be dropped
    @(negedge clk); rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    check("R2 glitch ignored", 32'(data_ready), 32'd0);
    send(9'h066, 8, 0, 2'b00, 1, "R2 after glitch");

    // R10 clocked mode
    cfg_sync = 1; rx_sclk = 1'b1;
    repeat (4) @(negedge clk);
    send(9'h096, 8, 0, 2'b00, 1, "R10 8N1");
    cfg_par_en = 1; cfg_par_odd = 1;
    send(9'h155, 9, 0, 2'b00, 1, "R10 9O1");
    cfg_par_en = 0; cfg_sync = 0;
    repeat (4) @(negedge clk);

    // R8 overrun, R9 irq gating
    auto_read = 1'b0; irq_en = 1'b0;
    send(9'h011, 8, 0, 2'b00, 0, "R8 first");
    send(9'h022, 8, 0, 2'b00, 0, "R8 second");
    check("R8 overrun set", 32'(overrun), 32'd1);
    check("R8 new data kept", 32'(rd_data), 32'h022);
    check("R8 ready", 32'(data_ready), 32'd1);
    check("R9 irq masked", 32'(irq), 32'd0);
    irq_en = 1'b1;
    #1;
    check("R9 irq enabled", 32'(irq), 32'd1);
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    check("R7 read clears ready", 32'(data_ready), 32'd0);
    check("R7 read clears overrun", 32'(overrun), 32'd0);

    repeat (10) @(negedge clk);
    check("R6 all characters seen", 32'(sb.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule